// File: doc/BRIEF.md
# Serial mode control register

This block takes configuration words from a host over a three-wire control port (serial data, shift clock, latch strobe). It stores the settings that steer a digital-to-analog datapath: soft mute, de-emphasis enable, de-emphasis sample-rate code, infinite zero detection, double-speed dubbing, left/right clock polarity, input format and input word length. The three control wires are sampled in the system clock domain through a synchronizer. Their edges are found there.

While the strobe is low, each rising edge of the shift clock moves one data bit into an 11-bit shift register, most significant bit first. On the rising edge of the strobe, the top three bits of the word choose one of two mode registers, and the low eight bits (B7..B0) are written into it. A word with any other prefix is dropped. A word with fewer than 11 bits since the last strobe is also dropped. The outputs are registered. They change only when a word is accepted or when reset is applied.

Top module: `smc_mode_ctl`

## Requirements
- R1: A synchronous active-high reset sets mute=0, deemph=0, rate=00 (44.1 kHz), zero_det=1, dbl_speed=0, lr_pol=0 (left channel while the sample clock is high), fmt_i2s=0 (normal format) and wlen=00 (16-bit).
- R2: While ctl_latch is low, each rising edge of ctl_sclk shifts ctl_data into an 11-bit word, MSB first. Word bits [10:8] are the prefix and bits [7:0] are B7..B0. The word is acted on at the rising edge of ctl_latch.
- R3: Prefix 100 writes the core register: B0=mute, B1=deemph, {B3,B2}=rate, B4=zero_det, B7=dbl_speed.
- R4: Prefix 101 writes the format register: B7=fmt_i2s (1 = I2S), B6=lr_pol, {B1,B0}=wlen.
- R5: A word with any prefix other than 100 or 101 leaves every output unchanged.
- R6: A word of fewer than 11 bits since the previous strobe rise is ignored. If more than 11 bits were shifted, only the last 11 are used.
- R7: Outputs hold their values between accepted words. Shift-clock edges while ctl_latch is high shift nothing and count nothing.
- R8: Writing one register leaves the fields of the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_data | input | 1 | Serial control data |
| ctl_sclk | input | 1 | Serial shift clock |
| ctl_latch | input | 1 | Latch strobe; shifting while low, word taken on rise |
| o_mute | output | 1 | Soft mute enable |
| o_deemph | output | 1 | De-emphasis enable |
| o_rate | output | 2 | De-emphasis sample-rate code |
| o_zero_det | output | 1 | Infinite zero detect enable |
| o_dbl_speed | output | 1 | Double-speed dubbing enable |
| o_lr_pol | output | 1 | Left/right sample clock polarity |
| o_fmt_i2s | output | 1 | Input format, 1 = I2S |
| o_wlen | output | 2 | Input word length code |

## Verification
The assertions assume that the host wires change slowly compared with clk, so that every level lasts several system clocks and each host edge shows up as exactly one detected edge. They also assume that ctl_data is stable around each ctl_sclk rise, and that reset is high at the first clock edge. The bench holds every control level for at least four system clocks, changes data only while the shift clock is low, and starts in reset. Under these conditions, a detected strobe rise is the only event that can change a stored field.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int WORD_W = 11;
  localparam int PFX_W  = 3;
  localparam int PAY_W  = WORD_W - PFX_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  localparam logic [PFX_W-1:0] PFX_CORE = 3'b100;
  localparam logic [PFX_W-1:0] PFX_FMT  = 3'b101;

  typedef struct packed {
    logic       mute;
    logic       deemph;
    logic [1:0] rate;
    logic       zero_det;
    logic       dbl;
  } core_t;

  typedef struct packed {
    logic       lr_pol;
    logic       fmt_i2s;
    logic [1:0] wlen;
  } fmt_t;

  localparam core_t CORE_DEF = '{mute: 1'b0, deemph: 1'b0, rate: 2'b00,
                                 zero_det: 1'b1, dbl: 1'b0};
  localparam fmt_t  FMT_DEF  = '{lr_pol: 1'b0, fmt_i2s: 1'b0, wlen: 2'b00};

  function automatic logic [PFX_W-1:0] prefix_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: PFX_W];
  endfunction

  function automatic logic [PAY_W-1:0] payload_of(input logic [WORD_W-1:0] w);
    return w[PAY_W-1:0];
  endfunction

  function automatic core_t core_from(input logic [PAY_W-1:0] p);
    core_t c;
    c.mute     = p[0];
    c.deemph   = p[1];
    c.rate     = p[3:2];
    c.zero_det = p[4];
    c.dbl      = p[7];
    return c;
  endfunction

  function automatic fmt_t fmt_from(input logic [PAY_W-1:0] p);
    fmt_t f;
    f.fmt_i2s = p[7];
    f.lr_pol  = p[6];
    f.wlen    = p[1:0];
    return f;
  endfunction
endpackage

// File: rtl/smc_sync_edge.sv
module smc_sync_edge #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] level,
  output logic [W-1:0] rise
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else     stg[s] <= stg[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= stg[STAGES-1];
  end

  assign level = stg[STAGES-1];
  assign rise  = stg[STAGES-1] & ~prev;
endmodule

// File: rtl/smc_shifter.sv
module smc_shifter
  import smc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              din,
  input  logic              clr,
  output logic [WORD_W-1:0] word,
  output logic              full
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      cnt  <= '0;
    end else if (clr) begin
      cnt  <= '0;
    end else if (shift_en) begin
      word <= {word[WORD_W-2:0], din};
      if (cnt != CNT_W'(WORD_W)) cnt <= cnt + 1'b1;
    end
  end

  assign full = (cnt == CNT_W'(WORD_W));
endmodule

// File: rtl/smc_regs.sv
module smc_regs
  import smc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             core_wr,
  input  logic             fmt_wr,
  input  logic [PAY_W-1:0] payload,
  output core_t            core_q,
  output fmt_t             fmt_q
);
  always_ff @(posedge clk) begin
    if (rst)          core_q <= CORE_DEF;
    else if (core_wr) core_q <= core_from(payload);
  end

  always_ff @(posedge clk) begin
    if (rst)         fmt_q <= FMT_DEF;
    else if (fmt_wr) fmt_q <= fmt_from(payload);
  end
endmodule

// File: rtl/smc_mode_ctl.sv
module smc_mode_ctl
  import smc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_data,
  input  logic       ctl_sclk,
  input  logic       ctl_latch,
  output logic       o_mute,
  output logic       o_deemph,
  output logic [1:0] o_rate,
  output logic       o_zero_det,
  output logic       o_dbl_speed,
  output logic       o_lr_pol,
  output logic       o_fmt_i2s,
  output logic [1:0] o_wlen
);
  localparam int LN_DATA  = 0;
  localparam int LN_SCLK  = 1;
  localparam int LN_LATCH = 2;

  logic [2:0]        lv, rs;
  logic              sclk_rise, latch_rise, latch_lvl, data_lvl;
  logic              shift_en, word_full, accept, core_wr, fmt_wr;
  logic [WORD_W-1:0] word;
  core_t             core_q;
  fmt_t              fmt_q;

  smc_sync_edge #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .din({ctl_latch, ctl_sclk, ctl_data}),
    .level(lv), .rise(rs)
  );

  assign data_lvl   = lv[LN_DATA];
  assign latch_lvl  = lv[LN_LATCH];
  assign sclk_rise  = rs[LN_SCLK];
  assign latch_rise = rs[LN_LATCH];
  assign shift_en   = sclk_rise & ~latch_lvl;

  smc_shifter u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .din(data_lvl),
    .clr(latch_rise), .word(word), .full(word_full)
  );

  assign accept  = latch_rise & word_full;
  assign core_wr = accept & (prefix_of(word) == PFX_CORE);
  assign fmt_wr  = accept & (prefix_of(word) == PFX_FMT);

  smc_regs u_regs (
    .clk(clk), .rst(rst), .core_wr(core_wr), .fmt_wr(fmt_wr),
    .payload(payload_of(word)), .core_q(core_q), .fmt_q(fmt_q)
  );

  assign o_mute      = core_q.mute;
  assign o_deemph    = core_q.deemph;
  assign o_rate      = core_q.rate;
  assign o_zero_det  = core_q.zero_det;
  assign o_dbl_speed = core_q.dbl;
  assign o_lr_pol    = fmt_q.lr_pol;
  assign o_fmt_i2s   = fmt_q.fmt_i2s;
  assign o_wlen      = fmt_q.wlen;
endmodule

// File: rtl/smc_mode_ctl_chk.sv
module smc_mode_ctl_chk
  import smc_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  latch_rise,
  input logic  word_full,
  input logic  core_wr,
  input logic  fmt_wr,
  input core_t core_q,
  input fmt_t  fmt_q
);
  p_reset_defaults_r1: assert property (@(posedge clk)
    rst |=> (core_q == CORE_DEF) && (fmt_q == FMT_DEF));

  p_hold_between_latches_r7: assert property (@(posedge clk) disable iff (rst)
    !latch_rise |=> $stable(core_q) && $stable(fmt_q));

  p_short_word_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (latch_rise && !word_full) |=> $stable(core_q) && $stable(fmt_q));

  p_unknown_prefix_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (latch_rise && !core_wr && !fmt_wr) |=> $stable(core_q) && $stable(fmt_q));

  p_core_keeps_fmt_r8: assert property (@(posedge clk) disable iff (rst)
    core_wr |=> $stable(fmt_q));

  p_fmt_keeps_core_r8: assert property (@(posedge clk) disable iff (rst)
    fmt_wr |=> $stable(core_q));

  p_single_target_r2: assert property (@(posedge clk) disable iff (rst)
    !(core_wr && fmt_wr));
endmodule

bind smc_mode_ctl smc_mode_ctl_chk u_chk (
  .clk(clk), .rst(rst), .latch_rise(latch_rise), .word_full(word_full),
  .core_wr(core_wr), .fmt_wr(fmt_wr), .core_q(core_q), .fmt_q(fmt_q)
);

// File: tb/smc_mode_ctl_bench.sv
module smc_mode_ctl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_data = 1'b0, ctl_sclk = 1'b0, ctl_latch = 1'b1;
  logic       o_mute, o_deemph, o_zero_det, o_dbl_speed, o_lr_pol, o_fmt_i2s;
  logic [1:0] o_rate, o_wlen;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  smc_mode_ctl u_smc_mode_ctl (
    .clk(clk), .rst(rst), .ctl_data(ctl_data), .ctl_sclk(ctl_sclk),
    .ctl_latch(ctl_latch), .o_mute(o_mute), .o_deemph(o_deemph),
    .o_rate(o_rate), .o_zero_det(o_zero_det), .o_dbl_speed(o_dbl_speed),
    .o_lr_pol(o_lr_pol), .o_fmt_i2s(o_fmt_i2s), .o_wlen(o_wlen)
  );

  // observed bus: {mute, deemph, rate[1:0], zero_det, dbl, lr_pol, fmt_i2s, wlen[1:0]}
  localparam logic [9:0] DEF = 10'b00_00_1_0_0_0_00;

  // {11-bit word, expected bus after it}
  localparam logic [20:0] VEC [7] = '{
    {11'b100_10000011, 10'b1100010000},  // R3 core write
    {11'b101_11000011, 10'b1100011111},  // R4 and R8 format write keeps core
    {11'b110_00000000, 10'b1100011111},  // R5 unknown prefix
    {11'b100_00011000, 10'b0010101111},  // R3 and R8 core write keeps format
    {11'b101_01000001, 10'b0010101001},  // R4 format write
    {11'b000_11111111, 10'b0010101001},  // R5 unknown prefix
    {11'b111_00000001, 10'b0010101001}   // R5 unknown prefix, LSB 1 for the R6 test
  };
  localparam string VREQ [7] = '{"R3", "R4", "R5", "R3", "R4", "R5", "R5"};

  task automatic chk(input string req, input logic [9:0] exp);
    logic [9:0] got;
    @(negedge clk);
    got = {o_mute, o_deemph, o_rate, o_zero_det, o_dbl_speed,
           o_lr_pol, o_fmt_i2s, o_wlen};
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic shift_bits(input logic [15:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ctl_data = w[i];
      repeat (4) @(negedge clk);
      ctl_sclk = 1'b1;
      repeat (4) @(negedge clk);
      ctl_sclk = 1'b0;
    end
  endtask

  task automatic send(input logic [15:0] w, input int n);
    ctl_latch = 1'b0;
    repeat (4) @(negedge clk);
    shift_bits(w, n);
    repeat (4) @(negedge clk);
    ctl_latch = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 power-on defaults", DEF);

    // R2: every table word is shifted MSB first and taken at the strobe
    for (int k = 0; k < 7; k++) begin
      send({5'b0, VEC[k][20:10]}, 11);
      chk(VREQ[k], VEC[k][9:0]);
    end

    // R6: 10 bits only; the window with the old LSB would read prefix 101
    send(16'b0000_0001_1111_1111, 10);
    chk("R6 short word", 10'b0010101001);

    // R6: 13 bits, only the last 11 count (prefix 100, rate 01)
    send({3'b0, 2'b11, 11'b100_00000100}, 13);
    chk("R6 long word", 10'b0001001001);

    // R7: shifting while the strobe is high, then a bare strobe pulse
    shift_bits({5'b0, 11'b101_11111111}, 11);
    ctl_latch = 1'b0;
    repeat (4) @(negedge clk);
    ctl_latch = 1'b1;
    repeat (8) @(negedge clk);
    chk("R7 shifts ignored while strobe high", 10'b0001001001);

    // R1: reset in mid-run
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset restores defaults", DEF);

    // R4: I2S select only, core stays at its defaults (R8)
    send({5'b0, 11'b101_10000000}, 11);
    chk("R4 i2s after reset", 10'b0000100100);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule